// File: doc/BRIEF.md
# System Control and Status Port

This block is an 8-bit control and status register that sits at a single I/O address. A write stores four enable bits. These bits open the timer-2 gate, let the timer-2 square wave reach the speaker, and arm the parity and channel error checks. Write bit 7 clears the timer-0 interrupt latch. Write bits 6 to 4 carry no function.

The read layout differs from the write layout. A read returns the following:

- the two latched error flags in the top bits;
- the live timer-2 output;
- a bit that flips on every refresh request;
- the four stored enable bits in the low nibble.

An error pulse is recorded only while its check is armed. Disarming a check wipes its flag. The timer-0 latch catches rising edges of the timer-0 output and drives the interrupt request. The timers themselves sit outside this block.

Top module: `sysctl_port`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` reads 0x00 while `tmr2_out` is 0, `irq0` is 0, `tmr2_gate` is 0 and `spkr_out` is 0.
- R2: A cycle with `wr_en` high stores `wr_data[3:0]`. From the next cycle, `rd_data[3:0]` returns those bits. `wr_data[6:4]` has no visible effect on any output.
- R3: `tmr2_gate` equals the stored enable bit 0.
- R4: `spkr_out` equals `tmr2_out` AND the stored enable bit 1, combinationally.
- R5: `rd_data[5]` equals `tmr2_out` in the same cycle.
- R6: When `parity_err` is high in a cycle whose stored bit 2 is 1, `rd_data[7]` is 1 from the next cycle. While bit 2 stays 1, `rd_data[7]` holds. A pulse while bit 2 is 0 leaves `rd_data[7]` at 0.
- R7: `chan_err` and stored bit 3 set `rd_data[6]` under the same rule as R6.
- R8: In the cycle after any cycle in which the matching enable bit is stored as 0, an error flag reads 0.
- R9: `irq0` becomes 1 in the cycle after a rising edge of `tmr0_out`. It then holds until it is cleared.
- R10: A write with `wr_data[7]` = 1 makes `irq0` read 0 from the next cycle, unless `tmr0_out` rises in that same cycle. In that case the new edge wins and `irq0` stays 1.
- R11: `rd_data[4]` inverts in the cycle after each cycle with `refresh_req` high. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (flags, timer-2 level, refresh toggle, enables) |
| parity_err | input | 1 | Memory parity error pulse |
| chan_err | input | 1 | I/O channel check pulse |
| tmr0_out | input | 1 | Timer-0 output level |
| tmr2_out | input | 1 | Timer-2 output level |
| refresh_req | input | 1 | Refresh request pulse |
| spkr_out | output | 1 | Gated speaker signal |
| tmr2_gate | output | 1 | Gate to timer 2 |
| irq0 | output | 1 | Latched timer-0 interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and two error checks. Every read bit position is therefore live, including both flag slots, which are produced by the same generated latch. The reference model then exercises both flag slots independently. It also covers the following cases:
- writes that arm and disarm the checks while pulses arrive;
- reserved-bit writes;
- back-to-back refresh pulses;
- an interrupt clear that lands in the same cycle as a new timer-0 edge.

// File: rtl/sysctl_pkg.sv
// Package: bit positions and sizes shared by the system control port.
// Assumes an 8-bit register; positions are the software-visible layout.
package sysctl_pkg;
    localparam int DATA_W     = 8;
    localparam int NUM_CHK    = 2;   // parity check and channel check
    localparam int EN_W       = 4;   // stored enable bits
    // write layout
    localparam int W_TMR2_GATE = 0;
    localparam int W_SPK_EN    = 1;
    localparam int W_PAR_EN    = 2;
    localparam int W_CHK_EN    = 3;
    localparam int W_IRQ_CLR   = 7;
    // read layout
    localparam int R_TOGGLE    = 4;
    localparam int R_TMR2      = 5;
    localparam int R_FLAG_LO   = 6;  // channel flag at 6, parity flag at 7
endpackage

// File: rtl/sysctl_err_latch.sv
// Error flag latch: records an error pulse while its check is enabled,
// and is wiped whenever the check is disabled. Assumes pulses are synchronous.
module sysctl_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic chk_en,
    input  logic err_pulse,
    output logic flag
);
    // Flag register: set on armed pulse, clear when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (!chk_en) flag <= 1'b0;
        else if (err_pulse) flag <= 1'b1;
    end

    a_r6_set_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && err_pulse) |=> flag);
    a_r6_hold_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && flag) |=> flag);
    a_r8_clear_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> !flag);
endmodule

// File: rtl/sysctl_edge_latch.sv
// Timer-0 interrupt latch: sets on a rising edge of the timer level,
// cleared by a software clear strobe; a coincident edge wins over the clear.
module sysctl_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic clr,
    output logic irq
);
    logic prev_q;
    logic rise;

    assign rise = level_in && !prev_q;

    // Previous-level register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_in;
    end

    // Interrupt latch: edge sets, clear strobe resets.
    always_ff @(posedge clk) begin
        if (!rst_n)    irq <= 1'b0;
        else if (rise) irq <= 1'b1;
        else if (clr)  irq <= 1'b0;
    end

    a_r9_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_in) |=> irq);
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !level_in) |=> !irq);
endmodule

// File: rtl/sysctl_toggle.sv
// Refresh toggle: a single bit that inverts once per refresh request cycle.
module sysctl_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic tog
);
    // Toggle register.
    always_ff @(posedge clk) begin
        if (!rst_n)   tog <= 1'b0;
        else if (req) tog <= !tog;
    end

    a_r11_flips: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (tog != $past(tog)));
    a_r11_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(tog));
endmodule

// File: rtl/sysctl_port.sv
// System control port: stores four enable bits, gates timer 2 and the speaker,
// latches error flags and the timer-0 interrupt, and assembles an asymmetric
// read word. Assumes all inputs are synchronous to clk.
module sysctl_port
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              parity_err,
    input  logic              chan_err,
    input  logic              tmr0_out,
    input  logic              tmr2_out,
    input  logic              refresh_req,
    output logic              spkr_out,
    output logic              tmr2_gate,
    output logic              irq0
);
    logic [EN_W-1:0]    en_q;
    logic [NUM_CHK-1:0] chk_en;
    logic [NUM_CHK-1:0] chk_pulse;
    logic [NUM_CHK-1:0] chk_flag;
    logic               tog;

    // Enable register: low nibble of each write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wr_data[EN_W-1:0];
    end

    // Index 0 is the channel check, index 1 the parity check (read bits 6, 7).
    assign chk_en    = {en_q[W_PAR_EN], en_q[W_CHK_EN]};
    assign chk_pulse = {parity_err, chan_err};

    for (genvar g = 0; g < NUM_CHK; g++) begin : g_chk
        sysctl_err_latch u_flag (
            .clk(clk), .rst_n(rst_n),
            .chk_en(chk_en[g]), .err_pulse(chk_pulse[g]), .flag(chk_flag[g])
        );
    end

    sysctl_edge_latch u_irq0 (
        .clk(clk), .rst_n(rst_n), .level_in(tmr0_out),
        .clr(wr_en && wr_data[W_IRQ_CLR]), .irq(irq0)
    );

    sysctl_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .req(refresh_req), .tog(tog)
    );

    // Output gating and read-word assembly.
    always_comb begin
        tmr2_gate = en_q[W_TMR2_GATE];
        spkr_out  = tmr2_out && en_q[W_SPK_EN];
        rd_data   = '0;
        rd_data[EN_W-1:0]                   = en_q;
        rd_data[R_TOGGLE]                   = tog;
        rd_data[R_TMR2]                     = tmr2_out;
        rd_data[R_FLAG_LO+NUM_CHK-1:R_FLAG_LO] = chk_flag;
    end

    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[EN_W-1:0] == $past(wr_data[EN_W-1:0])));
    a_r2_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data[EN_W-1:0]));
endmodule

// File: tb/sysctl_port_test.sv
module sysctl_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       parity_err = 1'b0, chan_err = 1'b0, tmr0_out = 1'b0;
    logic       tmr2_out = 1'b0, refresh_req = 1'b0;
    logic       spkr_out, tmr2_gate, irq0;

    int tests = 0, fails = 0, cycles = 0;
    bit checking = 1'b0;

    // reference model state
    bit [3:0] m_en;
    bit m_par, m_chk, m_irq, m_tog, m_t0prev;

    always #10 clk = !clk;   // 50 MHz

    sysctl_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .parity_err(parity_err), .chan_err(chan_err),
        .tmr0_out(tmr0_out), .tmr2_out(tmr2_out), .refresh_req(refresh_req),
        .spkr_out(spkr_out), .tmr2_gate(tmr2_gate), .irq0(irq0)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on each rising edge from the old state.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_par = 0; m_chk = 0; m_irq = 0; m_tog = 0; m_t0prev = 0;
        end else begin
            bit rise;
            rise = tmr0_out && !m_t0prev;
            m_par = m_en[2] ? (m_par || parity_err) : 1'b0;
            m_chk = m_en[3] ? (m_chk || chan_err) : 1'b0;
            if (rise) m_irq = 1'b1;
            else if (wr_en && wr_data[7]) m_irq = 1'b0;
            if (refresh_req) m_tog = !m_tog;
            m_t0prev = tmr0_out;
            if (wr_en) m_en = wr_data[3:0];
        end
    end

    // Compare every cycle, late in the low phase when inputs are settled.
    always @(negedge clk) begin
        #8;
        cycles++;
        if (checking) begin
            check("R2 enables", rd_data[3:0], m_en);
            check("R3 gate", tmr2_gate, m_en[0]);
            check("R4 speaker", spkr_out, tmr2_out & m_en[1]);
            check("R5 timer2 bit", rd_data[5], tmr2_out);
            check("R6 R8 parity flag", rd_data[7], m_par);
            check("R7 R8 channel flag", rd_data[6], m_chk);
            check("R9 R10 irq0", irq0, m_irq);
            check("R11 toggle", rd_data[4], m_tog);
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic cyc(input bit we, input logic [7:0] wd, input bit pe, input bit ce,
                       input bit t0, input bit t2, input bit rf);
        @(negedge clk);
        wr_en = we; wr_data = wd; parity_err = pe; chan_err = ce;
        tmr0_out = t0; tmr2_out = t2; refresh_req = rf;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #8;
        // R1 reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 irq0", irq0, 0);
        check("R1 gate", tmr2_gate, 0);
        check("R1 speaker", spkr_out, 0);
        checking = 1'b1;
        // R2 reserved bits only: no visible effect
        cyc(1, 8'h70, 0, 0, 0, 1, 0);
        cyc(0, 8'h00, 0, 0, 0, 1, 0);
        // R6/R7 pulses while disarmed are ignored
        cyc(0, 8'h00, 1, 1, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 0, 0, 0);
        // arm all, speaker on
        cyc(1, 8'h0F, 0, 0, 0, 1, 0);
        cyc(0, 8'h00, 1, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 1, 0, 1, 0);
        cyc(0, 8'h00, 0, 0, 0, 0, 0);
        // R8 disarm parity only
        cyc(1, 8'h0B, 0, 0, 0, 0, 0);
        cyc(0, 8'h00, 1, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 0, 0, 0);
        // R9 edge, R10 clear
        cyc(0, 8'h00, 0, 0, 1, 0, 0);
        cyc(0, 8'h00, 0, 0, 1, 0, 0);
        cyc(1, 8'h8B, 0, 0, 1, 0, 0);
        cyc(0, 8'h00, 0, 0, 0, 0, 0);
        // R10 clear coincident with new edge: edge wins
        cyc(1, 8'h8B, 0, 0, 1, 0, 0);
        cyc(0, 8'h00, 0, 0, 1, 0, 0);
        // R11 back-to-back refresh
        cyc(0, 8'h00, 0, 0, 0, 0, 1);
        cyc(0, 8'h00, 0, 0, 0, 0, 1);
        cyc(0, 8'h00, 0, 0, 0, 0, 1);
        cyc(0, 8'h00, 0, 0, 0, 0, 0);
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            cyc(($urandom % 6) == 0, d, ($urandom % 4) == 0, ($urandom % 4) == 0,
                ($urandom % 3) == 0, $urandom % 2, ($urandom % 3) == 0);
        end
        cyc(0, 8'h00, 0, 0, 0, 0, 0);
        @(negedge clk); #9;
        checking = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule